// File: doc/BRIEF.md
# Break-Even Shutdown Decision Unit

This block sits beside a subsystem that has two power states, on and off, and chooses on each idle period whether switching it off is worth the cost. When the subsystem goes idle, a strobe delivers a predicted idle length in time ticks. The block weighs the energy of staying on for that long against the energy of powering down, resting, and powering back up, where both transitions have their own power level and tick count. It commands a shutdown only when that comparison shows a strictly positive saving; no fixed timeout is involved.

Once off, the subsystem stays off until a task request arrives. The request starts the power-up sequence, and the task is acknowledged only after the power-up time has run out, so the wake-up latency falls on the task. A request that arrives while the power-down is still in progress waits for it to end and then starts the power-up at once, without resting in the off state. Time advances on a tick input, and an accumulator adds the power of the current state on every tick so the energy spent by a scenario can be checked against a hand-computed total.

Top module: `brkeven_pm_ctrl`

## Requirements
- R1: While reset is asserted and right after its release, `pm_mode` is 0 (on), `energy_acc` is 0, and `task_ack`, `pwr_off_cmd`, `pwr_on_cmd`, `dec_valid` and `dec_shut` are 0. The `pm_mode` encoding is 0 on, 1 evaluating, 2 powering down, 3 off, 4 powering up.
- R2: An `idle_start` pulse in mode 0 with `task_req` low captures `idle_pred` and moves to mode 1 at the next edge; at the edge after that, `dec_valid` pulses for one cycle and `dec_shut` is 1 exactly when idle_pred > T_DN+T_UP and P_ON*idle_pred > P_DN*T_DN + P_UP*T_UP + P_OFF*(idle_pred-T_DN-T_UP). With default parameters this means idle_pred of 13 or more.
- R3: A positive decision enters mode 2 with a one-cycle `pwr_off_cmd` pulse in the same cycle; after T_DN ticks the mode becomes 3. A negative decision returns to mode 0 with no command.
- R4: A `task_req` seen in mode 3 enters mode 4 at the next edge with a one-cycle `pwr_on_cmd` pulse; after T_UP ticks the mode becomes 0 and `task_ack` follows at the next edge. With a tick on every cycle, the ack appears T_UP+2 edges after the request.
- R5: A `task_req` that is high when the power-down completes sends the block straight from mode 2 to mode 4, with `pwr_on_cmd`, never entering mode 3.
- R6: In mode 0, `task_req` wins over a simultaneous `idle_start`, which is dropped. A `task_req` high in mode 1 vetoes the shutdown: the block returns to mode 0 with `dec_valid` 1 and `dec_shut` 0.
- R7: `task_req` is a level held until acknowledged; in mode 0 it is answered by a one-cycle `task_ack` at the next edge.
- R8: On every edge where `tick` is 1, `energy_acc` adds the power of the mode in force before that edge: P_ON in modes 0 and 1, P_DN in mode 2, P_OFF in mode 3, P_UP in mode 4. It saturates at its maximum.
- R9: Transition timers advance only on ticks: with `tick` low, modes 2 and 4 are held and `energy_acc` does not change.
- R10: `idle_start` has no effect outside mode 0: no decision is made and the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base enable, one per time unit |
| idle_start | input | 1 | Subsystem has gone idle (one-cycle pulse) |
| idle_pred | input | IDLE_W | Predicted idle length in ticks |
| task_req | input | 1 | Pending task, held until acknowledged |
| task_ack | output | 1 | Task accepted (one-cycle pulse) |
| pwr_off_cmd | output | 1 | Begin power-down (one-cycle pulse) |
| pwr_on_cmd | output | 1 | Begin power-up (one-cycle pulse) |
| dec_valid | output | 1 | A shutdown decision was made |
| dec_shut | output | 1 | The decision was to shut down |
| pm_mode | output | 3 | Current mode, encoded as in R1 |
| energy_acc | output | ACC_W | Accumulated energy in power-times-ticks units |

## Verification
Two functions can land on the same cycle: the shutdown decision and the arrival of work. The bench raises `task_req` in the very cycle `idle_start` is pulsed, and separately in the single evaluation cycle that follows a strobe, then judges that no power-down command is ever issued, that the decision reports no shutdown, and that the ack comes at the normal on-state latency. A request landing inside the power-down window is the third overlap, judged by a direct jump to power-up and a ack latency of T_UP+2 edges.

// File: rtl/bes_pkg.sv
package bes_pkg;

  typedef enum logic [2:0] {
    M_ON   = 3'd0,
    M_EVAL = 3'd1,
    M_DOWN = 3'd2,
    M_OFF  = 3'd3,
    M_UP   = 3'd4
  } pm_mode_e;

endpackage

// File: rtl/bes_breakeven.sv
// Combinational break-even test: shut down only if staying on for the
// predicted idle length costs strictly more than transitioning and resting.
module bes_breakeven #(
  parameter int IDLE_W = 16,
  parameter int PWR_W  = 16,
  parameter int P_ON   = 10,
  parameter int P_OFF  = 0,
  parameter int P_DN   = 40,
  parameter int P_UP   = 40,
  parameter int T_DN   = 1,
  parameter int T_UP   = 2
) (
  input  logic [IDLE_W-1:0] idle_len,
  output logic              shut
);

  localparam int PRD_W  = IDLE_W + PWR_W + 2;
  localparam int T_TOT  = T_DN + T_UP;
  localparam int E_XFER = P_DN * T_DN + P_UP * T_UP;

  logic [PRD_W-1:0] len_ext;
  logic [PRD_W-1:0] rest_len;
  logic [PRD_W-1:0] e_stay;
  logic [PRD_W-1:0] e_go;
  logic             long_enough;

  always_comb begin
    len_ext     = PRD_W'(idle_len);
    long_enough = (idle_len > IDLE_W'(T_TOT));
    rest_len    = long_enough ? (len_ext - PRD_W'(T_TOT)) : '0;
    e_stay      = PRD_W'(P_ON) * len_ext;
    e_go        = PRD_W'(E_XFER) + PRD_W'(P_OFF) * rest_len;
    shut        = long_enough && (e_stay > e_go);
  end

endmodule

// File: rtl/bes_xfer_timer.sv
// Tick counter for the power-down and power-up windows.
module bes_xfer_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] lim,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    done   = run && (cnt_q == lim - CNT_W'(1));
    cnt_en = clr || run;
    cnt_d  = clr ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bes_energy_meter.sv
// Adds the present power level once per tick.
module bes_energy_meter #(
  parameter int PWR_W = 16,
  parameter int ACC_W = 32,
  parameter bit SAT   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PWR_W-1:0] pwr,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_d;

  assign sum = {1'b0, acc} + (ACC_W+1)'(pwr);

  generate
    if (SAT) begin : g_sat
      assign acc_d = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    end else begin : g_wrap
      assign acc_d = sum[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (tick) begin
      acc <= acc_d;
    end
  end

endmodule

// File: rtl/brkeven_pm_ctrl.sv
module brkeven_pm_ctrl
  import bes_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int PWR_W  = 16,
  parameter int ACC_W  = 32,
  parameter int P_ON   = 10,
  parameter int P_OFF  = 0,
  parameter int P_DN   = 40,
  parameter int P_UP   = 40,
  parameter int T_DN   = 1,
  parameter int T_UP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              idle_start,
  input  logic [IDLE_W-1:0] idle_pred,
  input  logic              task_req,
  output logic              task_ack,
  output logic              pwr_off_cmd,
  output logic              pwr_on_cmd,
  output logic              dec_valid,
  output logic              dec_shut,
  output logic [2:0]        pm_mode,
  output logic [ACC_W-1:0]  energy_acc
);

  localparam int T_MAX = (T_DN > T_UP) ? T_DN : T_UP;
  localparam int CNT_W = $clog2(T_MAX + 1);

  pm_mode_e          st_q, st_d;
  logic [IDLE_W-1:0] pred_q;
  logic              pred_ld;
  logic              shut_ok;
  logic              in_xfer, xfer_clr, xfer_done;
  logic [CNT_W-1:0]  xfer_lim;
  logic [PWR_W-1:0]  pwr_now;
  logic              ack_d, off_d, on_d, dv_d, ds_d;
  logic              ack_q, off_q, on_q, dv_q, ds_q;

  bes_breakeven #(
    .IDLE_W(IDLE_W), .PWR_W(PWR_W), .P_ON(P_ON), .P_OFF(P_OFF),
    .P_DN(P_DN), .P_UP(P_UP), .T_DN(T_DN), .T_UP(T_UP)
  ) u_be (
    .idle_len(pred_q),
    .shut    (shut_ok)
  );

  assign in_xfer  = (st_q == M_DOWN) || (st_q == M_UP);
  assign xfer_lim = (st_q == M_UP) ? CNT_W'(T_UP) : CNT_W'(T_DN);
  assign xfer_clr = (st_d != st_q);

  bes_xfer_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (xfer_clr),
    .run  (in_xfer && tick),
    .lim  (xfer_lim),
    .done (xfer_done)
  );

  // next-state process
  always_comb begin
    st_d    = st_q;
    pred_ld = 1'b0;
    ack_d   = 1'b0;
    off_d   = 1'b0;
    on_d    = 1'b0;
    dv_d    = 1'b0;
    ds_d    = 1'b0;
    unique case (st_q)
      M_ON: begin
        if (task_req) begin
          ack_d = !ack_q;
        end else if (idle_start) begin
          pred_ld = 1'b1;
          st_d    = M_EVAL;
        end
      end
      M_EVAL: begin
        dv_d = 1'b1;
        if (!task_req && shut_ok) begin
          ds_d  = 1'b1;
          off_d = 1'b1;
          st_d  = M_DOWN;
        end else begin
          st_d = M_ON;
        end
      end
      M_DOWN: begin
        if (xfer_done) begin
          if (task_req) begin
            st_d = M_UP;
            on_d = 1'b1;
          end else begin
            st_d = M_OFF;
          end
        end
      end
      M_OFF: begin
        if (task_req) begin
          st_d = M_UP;
          on_d = 1'b1;
        end
      end
      M_UP: begin
        if (xfer_done) begin
          st_d = M_ON;
        end
      end
      default: st_d = M_ON;
    endcase
  end

  always_comb begin
    unique case (st_q)
      M_DOWN:  pwr_now = PWR_W'(P_DN);
      M_OFF:   pwr_now = PWR_W'(P_OFF);
      M_UP:    pwr_now = PWR_W'(P_UP);
      default: pwr_now = PWR_W'(P_ON);
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_ON;
      ack_q <= 1'b0;
      off_q <= 1'b0;
      on_q  <= 1'b0;
      dv_q  <= 1'b0;
      ds_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
      off_q <= off_d;
      on_q  <= on_d;
      dv_q  <= dv_d;
      ds_q  <= ds_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
    end else if (pred_ld) begin
      pred_q <= idle_pred;
    end
  end

  bes_energy_meter #(.PWR_W(PWR_W), .ACC_W(ACC_W), .SAT(1'b1)) u_em (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .pwr  (pwr_now),
    .acc  (energy_acc)
  );

  assign task_ack    = ack_q;
  assign pwr_off_cmd = off_q;
  assign pwr_on_cmd  = on_q;
  assign dec_valid   = dv_q;
  assign dec_shut    = ds_q;
  assign pm_mode     = st_q;

endmodule

// File: rtl/brkeven_pm_ctrl_chk.sv
module brkeven_pm_ctrl_chk #(
  parameter int IDLE_W = 16,
  parameter int ACC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              idle_start,
  input logic [IDLE_W-1:0] idle_pred,
  input logic              task_req,
  input logic              task_ack,
  input logic              pwr_off_cmd,
  input logic              pwr_on_cmd,
  input logic              dec_valid,
  input logic              dec_shut,
  input logic [2:0]        pm_mode,
  input logic [ACC_W-1:0]  energy_acc
);

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode <= 3'd4);

  assert_shut_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_shut |-> dec_valid);

  assert_offcmd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_cmd |-> (pm_mode == 3'd2) && ($past(pm_mode) == 3'd1));

  assert_oncmd_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on_cmd |-> (pm_mode == 3'd4) && ($past(pm_mode) == 3'd3 || $past(pm_mode) == 3'd2));

  assert_off_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 3'd3) |=> (pm_mode == 3'd3 || pm_mode == 3'd4));

  assert_pulses_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwr_off_cmd, pwr_on_cmd, task_ack}));

  assert_veto_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 3'd1 && task_req) |=> (pm_mode == 3'd0) && !dec_shut && !pwr_off_cmd);

  assert_ack_in_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    task_ack |-> (pm_mode == 3'd0) && ($past(pm_mode) == 3'd0));

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(energy_acc));

  assert_up_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && pm_mode == 3'd4) |=> (pm_mode == 3'd4));

  assert_down_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && pm_mode == 3'd2) |=> (pm_mode == 3'd2));

  assert_strobe_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_start && pm_mode == 3'd3) |=> !dec_valid);

endmodule

bind brkeven_pm_ctrl brkeven_pm_ctrl_chk #(.IDLE_W(IDLE_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .idle_start (idle_start),
  .idle_pred  (idle_pred),
  .task_req   (task_req),
  .task_ack   (task_ack),
  .pwr_off_cmd(pwr_off_cmd),
  .pwr_on_cmd (pwr_on_cmd),
  .dec_valid  (dec_valid),
  .dec_shut   (dec_shut),
  .pm_mode    (pm_mode),
  .energy_acc (energy_acc)
);

// File: tb/brkeven_pm_ctrl_test.sv
module brkeven_pm_ctrl_test;

  localparam int CLK_P  = 10;
  localparam int IDLE_W = 16;
  localparam int ACC_W  = 32;
  localparam int P_ON   = 10;
  localparam int P_OFF  = 0;
  localparam int P_DN   = 40;
  localparam int P_UP   = 40;
  localparam int T_DN   = 1;
  localparam int T_UP   = 2;

  logic              clk;
  logic              rst_n;
  logic              tick;
  logic              idle_start;
  logic [IDLE_W-1:0] idle_pred;
  logic              task_req;
  logic              task_ack;
  logic              pwr_off_cmd;
  logic              pwr_on_cmd;
  logic              dec_valid;
  logic              dec_shut;
  logic [2:0]        pm_mode;
  logic [ACC_W-1:0]  energy_acc;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  brkeven_pm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .idle_start(idle_start),
    .idle_pred(idle_pred), .task_req(task_req), .task_ack(task_ack),
    .pwr_off_cmd(pwr_off_cmd), .pwr_on_cmd(pwr_on_cmd),
    .dec_valid(dec_valid), .dec_shut(dec_shut), .pm_mode(pm_mode),
    .energy_acc(energy_acc)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic bit exp_shut(input longint len);
    longint tt = T_DN + T_UP;
    if (len <= tt) return 1'b0;
    return (P_ON * len) > (P_DN * T_DN + P_UP * T_UP + P_OFF * (len - tt));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Raise a request, count edges until ack is seen, then drop it.
  task automatic req_until_ack(output int lat);
    task_req = 1'b1;
    lat = 0;
    do begin
      step();
      lat++;
    end while (!task_ack && lat < 40);
    task_req = 1'b0;
  endtask

  task automatic go_off(input int len);
    idle_pred  = IDLE_W'(len);
    idle_start = 1'b1;
    step();
    idle_start = 1'b0;
    step();
    repeat (T_DN) step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick = 1'b0; idle_start = 1'b0; idle_pred = '0; task_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", pm_mode, 0);
    rst_n = 1'b1;
    chk("R1 acc after reset", energy_acc, 0);
    chk("R1 outputs idle", {task_ack, pwr_off_cmd, pwr_on_cmd, dec_valid, dec_shut}, 0);
    tick = 1'b1;
  endtask

  task automatic t_decide(input int len);
    bit e = exp_shut(len);
    int lat;
    idle_pred  = IDLE_W'(len);
    idle_start = 1'b1;
    step();
    idle_start = 1'b0;
    chk("R2 eval mode", pm_mode, 1);
    step();
    chk("R2 dec_valid", dec_valid, 1);
    chk("R2 dec_shut", dec_shut, e);
    chk("R3 mode after decision", pm_mode, e ? 2 : 0);
    chk("R3 off cmd", pwr_off_cmd, e);
    if (e) begin
      repeat (T_DN) step();
      chk("R3 reach off", pm_mode, 3);
      req_until_ack(lat);
    end
    step();
    chk("R2 dec_valid pulse ends", dec_valid, 0);
  endtask

  task automatic t_shut_wake_energy();
    longint e0, e1;
    int lat;
    e0 = energy_acc;
    go_off(13);
    chk("R3 off after T_DN", pm_mode, 3);
    chk("R3 off cmd pulse ended", pwr_off_cmd, 0);
    repeat (3) step();
    chk("R4 stays off", pm_mode, 3);
    task_req = 1'b1;
    step();
    chk("R4 up mode", pm_mode, 4);
    chk("R4 on cmd", pwr_on_cmd, 1);
    lat = 1;
    while (!task_ack && lat < 40) begin
      step();
      lat++;
    end
    task_req = 1'b0;
    chk("R4 wake latency", lat, T_UP + 2);
    e1 = energy_acc;
    chk("R8 energy of cycle", e1 - e0,
        2*P_ON + T_DN*P_DN + 4*P_OFF + T_UP*P_UP + P_ON);
    step();
    chk("R7 ack is one cycle", task_ack, 0);
  endtask

  task automatic t_task_in_on();
    int lat;
    req_until_ack(lat);
    chk("R7 ack latency in on", lat, 1);
    step();
    chk("R7 ack dropped", task_ack, 0);
  endtask

  task automatic t_task_during_down();
    longint e0;
    int lat;
    e0 = energy_acc;
    idle_pred  = IDLE_W'(100);
    idle_start = 1'b1;
    step();
    idle_start = 1'b0;
    step();
    chk("R5 in power-down", pm_mode, 2);
    task_req = 1'b1;
    step();
    chk("R5 direct to up", pm_mode, 4);
    chk("R5 on cmd", pwr_on_cmd, 1);
    lat = 1;
    while (!task_ack && lat < 40) begin
      step();
      chk("R5 never off", (pm_mode == 3'd3), 0);
      lat++;
    end
    task_req = 1'b0;
    chk("R5 latency", lat, T_UP + 2);
    chk("R8 energy during overlap", energy_acc - e0,
        2*P_ON + T_DN*P_DN + T_UP*P_UP + P_ON);
    step();
  endtask

  task automatic t_collide_strobe();
    idle_pred  = IDLE_W'(50);
    idle_start = 1'b1;
    task_req   = 1'b1;
    step();
    idle_start = 1'b0;
    task_req   = 1'b0;
    chk("R6 task wins ack", task_ack, 1);
    chk("R6 strobe dropped", pm_mode, 0);
    step();
    chk("R6 no decision", dec_valid, 0);
    chk("R6 still on", pm_mode, 0);
  endtask

  task automatic t_veto_in_eval();
    int lat;
    idle_pred  = IDLE_W'(50);
    idle_start = 1'b1;
    step();
    idle_start = 1'b0;
    chk("R6 eval reached", pm_mode, 1);
    task_req = 1'b1;
    step();
    chk("R6 veto back on", pm_mode, 0);
    chk("R6 veto valid", dec_valid, 1);
    chk("R6 veto no shut", dec_shut, 0);
    chk("R6 veto no off cmd", pwr_off_cmd, 0);
    lat = 0;
    while (!task_ack && lat < 40) begin
      step();
      lat++;
    end
    task_req = 1'b0;
    chk("R7 ack after veto", lat, 1);
    step();
  endtask

  task automatic t_tick_gate();
    longint e0;
    int lat;
    go_off(50);
    chk("R9 off reached", pm_mode, 3);
    tick = 1'b0;
    task_req = 1'b1;
    step();
    chk("R9 up without tick", pm_mode, 4);
    e0 = energy_acc;
    repeat (6) step();
    chk("R9 held in up", pm_mode, 4);
    chk("R9 no ack", task_ack, 0);
    chk("R8 acc frozen", energy_acc - e0, 0);
    tick = 1'b1;
    lat = 0;
    while (!task_ack && lat < 40) begin
      step();
      lat++;
    end
    task_req = 1'b0;
    chk("R9 resumes", lat, T_UP + 1);
    step();
  endtask

  task automatic t_strobe_ignored_off();
    int lat;
    go_off(40);
    idle_pred  = IDLE_W'(60);
    idle_start = 1'b1;
    step();
    idle_start = 1'b0;
    chk("R10 mode unchanged", pm_mode, 3);
    step();
    chk("R10 no decision", dec_valid, 0);
    chk("R10 still off", pm_mode, 3);
    req_until_ack(lat);
    chk("R4 wake again", lat, T_UP + 2);
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    step();
    t_decide(12);
    t_decide(3);
    t_decide(0);
    t_decide(13);
    t_decide(200);
    t_shut_wake_energy();
    t_task_in_on();
    t_task_during_down();
    t_collide_strobe();
    t_veto_in_eval();
    t_tick_gate();
    t_strobe_ignored_off();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule